// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block resolves one two-word jump instruction at a time. It checks the first word for the jump opcode and reads a four-bit condition field. It tests that field against the status flags (carry, overflow, negative, zero). It then reports the next program counter, either the sequential address or a PC-relative target.

The displacement is 24 bits wide and signed. Its upper byte sits in the low byte of the first word and its lower 16 bits fill the second word. The target is the address after the second word plus this sign-extended byte displacement, which gives a reach of roughly plus or minus 8 MiB.

A subroutine jump takes two steps. First the block issues a memory write of the return address to the location held in the stack pointer, and waits for the memory to accept it. Only then does it report the new program counter.

The controller has three states:
- `ST_IDLE`: waits for an instruction.
- `ST_PUSH`: holds the save request.
- `ST_DONE`: presents the result for one cycle.

Transitions:
- `ST_IDLE` goes to `ST_DONE` on an accepted conditional or unconditional jump.
- `ST_IDLE` goes to `ST_PUSH` on an accepted subroutine jump.
- `ST_IDLE` stays put for any other opcode.
- `ST_PUSH` stays while `mem_wr_ready` is low.
- `ST_PUSH` goes to `ST_DONE` on the cycle `mem_wr_ready` is seen high.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `branch_unit`

## Requirements
- R1: An accepted word pair whose first word has bits 15..12 different from 4'b0001 produces no `pc_valid` pulse and no write request.
- R2: Condition codes 4'b0001, 4'b0010, 4'b0100 and 4'b1000 take the jump when zero, negative, overflow or carry respectively is 1. `flags` is ordered {carry, overflow, negative, zero} from bit 3 down to bit 0.
- R3: Condition codes 4'b1110, 4'b1101, 4'b1011 and 4'b0111 take the jump when zero, negative, overflow or carry respectively is 0. Code 4'b0000 always takes it.
- R4: The offset is {first[7:0], second[15:0]}, sign-extended to 32 bits. A taken jump gives `pc_next` = `pc` + 4 + offset, modulo 2^32.
- R5: A jump whose condition fails gives `pc_valid` with `pc_taken` = 0 and `pc_next` = `pc` + 4.
- R6: Any condition code not listed in R2, R3 or R7 is never taken. It gives `pc_taken` = 0, `pc_next` = `pc` + 4 and `cond_err` = 1, all with `pc_valid`.
- R7: Code 4'b1111 (subroutine jump) raises `mem_wr_req` with `mem_wr_addr` = stack pointer and `mem_wr_data` = `pc` + 4. The request is held unchanged until `mem_wr_ready` is seen high.
- R8: For a subroutine jump, `pc_valid` with `pc_taken` = 1 and the R4 target appears in the cycle after the write is accepted, and never before.
- R9: For non-subroutine jumps, `pc_valid` appears in the cycle after the instruction is accepted. It is always a single-cycle pulse.
- R10: `instr_ready` is low whenever the unit is busy. An `instr_valid` during that time is ignored.
- R11: After reset the unit is idle: `instr_ready` = 1, and `pc_valid`, `mem_wr_req` and `cond_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word pair present |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_first | input | 16 | First instruction word (opcode, condition, offset high byte) |
| instr_second | input | 16 | Second instruction word (offset low 16 bits) |
| flags | input | 4 | Status flags {carry, overflow, negative, zero} |
| pc | input | 32 | Byte address of the first instruction word |
| sp | input | 32 | Stack pointer used as the save address |
| pc_valid | output | 1 | Single-cycle strobe: next-PC result valid |
| pc_next | output | 32 | Next program counter |
| pc_taken | output | 1 | Jump taken |
| cond_err | output | 1 | Undefined condition code seen |
| mem_wr_req | output | 1 | Return-address write request |
| mem_wr_addr | output | 32 | Write address (stack pointer) |
| mem_wr_data | output | 32 | Return address to store |
| mem_wr_ready | input | 1 | Memory accepts the write |

## Verification
The bench sweeps all sixteen condition codes against all sixteen flag patterns. It mixes in displacements at both reach limits and a program counter near the top of the address space. Each case shows a specific failure:
- A design with the set/clear decoding swapped or mis-indexed takes the wrong branch for one flag.
- One that zero-extends the offset jumps forward on a negative displacement.
- One that uses the first-word address as base lands four bytes short.
- An undefined code treated as a jump, or without its error flag, shows up against R6.

Subroutine jumps are run with zero to two cycles of memory back-pressure, with a second instruction offered while busy. A design that updates the program counter before the store is accepted is caught there, and so is one that lets the request wander or accepts the stray instruction.

// File: rtl/branch_unit_pkg.sv
package branch_unit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } br_state_e;

    localparam int unsigned OPC_W = 4;
    localparam logic [OPC_W-1:0] OPC_JUMP = 4'b0001;

endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval #(
    parameter int unsigned NFLAGS = 4
) (
    input  logic [NFLAGS-1:0] cond,
    input  logic [NFLAGS-1:0] flag_vec,
    output logic              take,
    output logic              is_call,
    output logic              bad_code
);
    localparam logic [NFLAGS-1:0] ONE = 1;

    logic [NFLAGS-1:0] hit_set;
    logic [NFLAGS-1:0] hit_clr;

    genvar k;
    generate
        for (k = 0; k < NFLAGS; k++) begin : g_flag
            always_comb begin
                hit_set[k] = (cond == (ONE << k));
                hit_clr[k] = (cond == ~(ONE << k));
            end
        end
    endgenerate

    logic always_code;

    always_comb begin
        always_code = (cond == '0);
        is_call     = (cond == '1);
        take        = always_code | is_call
                    | (|(hit_set & flag_vec))
                    | (|(hit_clr & ~flag_vec));
        bad_code    = ~(always_code | is_call | (|hit_set) | (|hit_clr));
    end

endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
    parameter int unsigned AW    = 32,
    parameter int unsigned OFS_W = 24,
    parameter int unsigned STEP  = 4
) (
    input  logic [AW-1:0]    base_pc,
    input  logic [OFS_W-1:0] offset,
    output logic [AW-1:0]    seq_pc,
    output logic [AW-1:0]    target_pc
);
    localparam int unsigned EXT_W = AW - OFS_W;
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] ofs_ext;

    always_comb begin
        ofs_ext   = {{EXT_W{offset[OFS_W-1]}}, offset};
        seq_pc    = base_pc + STEP_V;
        target_pc = seq_pc + ofs_ext;
    end

endmodule

// File: rtl/branch_unit.sv
module branch_unit
    import branch_unit_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned WW     = 16,
    parameter int unsigned NFLAGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [WW-1:0]     instr_first,
    input  logic [WW-1:0]     instr_second,
    input  logic [NFLAGS-1:0] flags,
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     sp,
    output logic              pc_valid,
    output logic [AW-1:0]     pc_next,
    output logic              pc_taken,
    output logic              cond_err,
    output logic              mem_wr_req,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [AW-1:0]     mem_wr_data,
    input  logic              mem_wr_ready
);
    localparam int unsigned HI_OFS_W    = WW - OPC_W - NFLAGS;
    localparam int unsigned OFS_W       = WW + HI_OFS_W;
    localparam int unsigned INSTR_BYTES = 2 * (WW / 8);

    br_state_e state_q, state_d;

    logic [OPC_W-1:0]  opc;
    logic [NFLAGS-1:0] cond;
    logic [OFS_W-1:0]  offset;

    always_comb begin
        opc    = instr_first[WW-1 -: OPC_W];
        cond   = instr_first[WW-OPC_W-1 -: NFLAGS];
        offset = {instr_first[HI_OFS_W-1:0], instr_second};
    end

    logic take, is_call, bad_code;

    branch_cond_eval #(.NFLAGS(NFLAGS)) u_cond (
        .cond     (cond),
        .flag_vec (flags),
        .take     (take),
        .is_call  (is_call),
        .bad_code (bad_code)
    );

    logic [AW-1:0] seq_pc, target_pc;

    branch_target_calc #(.AW(AW), .OFS_W(OFS_W), .STEP(INSTR_BYTES)) u_tgt (
        .base_pc   (pc),
        .offset    (offset),
        .seq_pc    (seq_pc),
        .target_pc (target_pc)
    );

    logic accept_jump;
    always_comb accept_jump = instr_valid && (state_q == ST_IDLE) && (opc == OPC_JUMP);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept_jump) state_d = is_call ? ST_PUSH : ST_DONE;
            ST_PUSH: if (mem_wr_ready) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result and save-request holding registers
    logic [AW-1:0] res_pc_q, save_addr_q, save_data_q;
    logic          res_taken_q, res_err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_pc_q    <= '0;
            res_taken_q <= 1'b0;
            res_err_q   <= 1'b0;
            save_addr_q <= '0;
            save_data_q <= '0;
        end else if (accept_jump) begin
            res_pc_q    <= take ? target_pc : seq_pc;
            res_taken_q <= take;
            res_err_q   <= bad_code;
            save_addr_q <= sp;
            save_data_q <= seq_pc;
        end
    end

    // outputs
    always_comb begin
        instr_ready = 1'b0;
        pc_valid    = 1'b0;
        pc_taken    = 1'b0;
        cond_err    = 1'b0;
        pc_next     = res_pc_q;
        mem_wr_req  = 1'b0;
        mem_wr_addr = save_addr_q;
        mem_wr_data = save_data_q;
        unique case (state_q)
            ST_IDLE: instr_ready = 1'b1;
            ST_PUSH: mem_wr_req  = 1'b1;
            ST_DONE: begin
                pc_valid = 1'b1;
                pc_taken = res_taken_q;
                cond_err = res_err_q;
            end
            default: instr_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned WW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic          instr_ready,
    input logic [WW-1:0] instr_first,
    input logic          pc_valid,
    input logic          pc_taken,
    input logic          cond_err,
    input logic          mem_wr_req,
    input logic [AW-1:0] mem_wr_addr,
    input logic [AW-1:0] mem_wr_data,
    input logic          mem_wr_ready
);
    // R1
    no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && instr_first[WW-1 -: 4] != 4'b0001)
        |=> (!pc_valid && !mem_wr_req));

    // R6
    err_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_err |-> (pc_valid && !pc_taken));

    // R7
    save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ready)
        |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R8
    jump_after_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_ready) |=> (pc_valid && pc_taken && !mem_wr_req));

    // R8
    no_early_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> !pc_valid);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |=> !pc_valid);

    // R10
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req || pc_valid) |-> !instr_ready);

endmodule

bind branch_unit branch_unit_chk #(.AW(AW), .WW(WW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr_ready  (instr_ready),
    .instr_first  (instr_first),
    .pc_valid     (pc_valid),
    .pc_taken     (pc_taken),
    .cond_err     (cond_err),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ready (mem_wr_ready)
);

// File: tb/tb_branch_unit.sv
module tb_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [15:0] instr_first = '0;
    logic [15:0] instr_second = '0;
    logic [3:0]  flags = '0;
    logic [31:0] pc = '0;
    logic [31:0] sp = '0;
    logic        pc_valid;
    logic [31:0] pc_next;
    logic        pc_taken;
    logic        cond_err;
    logic        mem_wr_req;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ready = 1'b0;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    branch_unit dut (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_first(instr_first), .instr_second(instr_second),
        .flags(flags), .pc(pc), .sp(sp),
        .pc_valid(pc_valid), .pc_next(pc_next), .pc_taken(pc_taken),
        .cond_err(cond_err), .mem_wr_req(mem_wr_req),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(mem_wr_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected decision from the condition table
    function automatic logic exp_take(input logic [3:0] c, input logic [3:0] f);
        case (c)
            4'b0000: return 1'b1;
            4'b0001: return f[0];
            4'b0010: return f[1];
            4'b0100: return f[2];
            4'b1000: return f[3];
            4'b1110: return !f[0];
            4'b1101: return !f[1];
            4'b1011: return !f[2];
            4'b0111: return !f[3];
            4'b1111: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_bad(input logic [3:0] c);
        case (c)
            4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
            4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b1111: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic run_jump(input logic [3:0] c, input logic [3:0] f,
                            input logic [31:0] p, input logic [31:0] s,
                            input logic [23:0] ofs, input int wait_cyc);
        logic [31:0] seq, tgt, ext;
        logic        tk;
        seq = p + 32'd4;
        ext = {{8{ofs[23]}}, ofs};
        tgt = seq + ext;
        tk  = exp_take(c, f);
        chk("R10 ready when idle", {31'd0, instr_ready}, 32'd1);
        instr_first  = {4'b0001, c, ofs[23:16]};
        instr_second = ofs[15:0];
        flags = f; pc = p; sp = s;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        if (c == 4'b1111) begin
            // R7
            chk("R7 req", {31'd0, mem_wr_req}, 32'd1);
            chk("R7 addr", mem_wr_addr, s);
            chk("R7 data", mem_wr_data, seq);
            chk("R8 no early pc", {31'd0, pc_valid}, 32'd0);
            for (int w = 0; w < wait_cyc; w++) begin
                // R10: offer another jump while busy; it must be dropped
                chk("R10 busy", {31'd0, instr_ready}, 32'd0);
                instr_first = 16'h1000; instr_second = 16'h0040;
                pc = p ^ 32'h0000_1000;
                instr_valid = 1'b1;
                @(negedge clk);
                instr_valid = 1'b0;
                chk("R7 held req", {31'd0, mem_wr_req}, 32'd1);
                chk("R7 held addr", mem_wr_addr, s);
                chk("R7 held data", mem_wr_data, seq);
                chk("R8 no pc while waiting", {31'd0, pc_valid}, 32'd0);
            end
            mem_wr_ready = 1'b1;
            @(negedge clk);
            mem_wr_ready = 1'b0;
            chk("R8 pc_valid", {31'd0, pc_valid}, 32'd1);
            chk("R8 taken", {31'd0, pc_taken}, 32'd1);
            chk("R8 R4 target", pc_next, tgt);
            chk("R8 req dropped", {31'd0, mem_wr_req}, 32'd0);
        end else begin
            chk("R9 pc_valid", {31'd0, pc_valid}, 32'd1);
            chk("R2 R3 R5 taken", {31'd0, pc_taken}, {31'd0, tk});
            chk("R4 R5 next pc", pc_next, tk ? tgt : seq);
            chk("R6 err flag", {31'd0, cond_err}, {31'd0, exp_bad(c)});
            chk("R7 no req", {31'd0, mem_wr_req}, 32'd0);
        end
        @(negedge clk);
        chk("R9 single pulse", {31'd0, pc_valid}, 32'd0);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [23:0] ofs_tab [4];
        logic [31:0] pc_tab [4];
        ofs_tab[0] = 24'h7FFFFF; ofs_tab[1] = 24'h800001;
        ofs_tab[2] = 24'h000000; ofs_tab[3] = 24'hFFFFF0;
        pc_tab[0]  = 32'h0000_1000; pc_tab[1] = 32'h0080_0000;
        pc_tab[2]  = 32'hFFFF_FFF8; pc_tab[3] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        chk("R11 ready", {31'd0, instr_ready}, 32'd1);
        chk("R11 pc_valid", {31'd0, pc_valid}, 32'd0);
        chk("R11 req", {31'd0, mem_wr_req}, 32'd0);
        chk("R11 err", {31'd0, cond_err}, 32'd0);

        // R1: every non-jump opcode is ignored
        for (int op = 0; op < 16; op++) begin
            if (op != 1) begin
                instr_first = {op[3:0], 12'hF7F};
                instr_second = 16'hFFFF;
                instr_valid = 1'b1;
                @(negedge clk);
                instr_valid = 1'b0;
                chk("R1 no pc", {31'd0, pc_valid}, 32'd0);
                chk("R1 no req", {31'd0, mem_wr_req}, 32'd0);
                chk("R1 still ready", {31'd0, instr_ready}, 32'd1);
            end
        end

        // R2 R3 R4 R5 R6 R7 R8: all codes against all flag patterns
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                run_jump(c[3:0], f[3:0], pc_tab[(c + f) % 4] + 32'(f * 8),
                         32'h0000_F000 - 32'(c * 4), ofs_tab[(c + 2 * f) % 4], f % 3);
            end
        end

        // R4 reach extremes
        run_jump(4'b0000, 4'h0, 32'h0100_0000, 32'h0, 24'h800000, 0);
        run_jump(4'b1111, 4'h0, 32'h0000_0010, 32'h0000_2000, 24'h7FFFFF, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule